// File: doc/BRIEF.md
# Transmit/Receive Bias and Switch Controller

This block is the digital side of a four-channel transmit/receive front end. A small register file, loaded through a one-cycle write strobe, holds two 8-bit codes for each of five bias DAC channels: one per power amplifier and one shared by the low-noise amplifiers. One code biases the amplifier on and the other biases it off. The block picks one of the two codes for each channel and drives it to that DAC.

A mode bit selects how the codes are chosen. In direct mode, each DAC code is the on code last written. In automatic mode, each channel switches between its on and off codes as the transmit/receive state changes. The state comes either from two register enable bits or from an external TR pin, which passes through a two-flop synchronizer. The same state drives the external transmit/receive switch. That switch has a programmable polarity and an enable. A polarization switch follows its own register bit and has its own enable. The shared low-noise channel also has an output-enable that, when cleared, asks the analog stage to float that output.

Every output comes from a flop, so a change of state reaches all outputs on the same clock edge. Codes pass to the DAC without modification.

Top module: `trx_bias_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, every output is zero after that edge: all DAC codes 0x00, the low-noise output-enable low, and both switch outputs low. All registers clear, so the block starts in direct mode with both switch drivers disabled.
- R2: A write sampled at a rising edge stores wr_data at wr_addr. The addresses are: on code of channel c at c, off code of channel c at 8+c, control at 0x10, switch control at 0x11. Channels 0 to 3 are the power amplifiers and channel 4 is the low-noise amplifier. The outputs show the new value after the next rising edge, not before it.
- R3: With control bit 0 clear (direct mode), every DAC output equals its channel's on code. Off codes, the TR pin and the enable bits have no effect on the DAC outputs.
- R4: With control bit 0 set (automatic mode): in transmit, the four power-amplifier channels output their on codes and the low-noise channel outputs its off code. In receive, the reverse applies. In idle, every channel outputs its off code.
- R5: With control bit 1 clear, the state comes from the register enables. Transmit bit 2 alone gives transmit and receive bit 3 alone gives receive. Both set or both clear gives idle. With control bit 1 set, the synchronized TR pin decides: high is transmit and low is receive. The enable bits then have no effect.
- R6: A TR pin change is not visible at the outputs after two rising edges and is visible after the third.
- R7: Codes reach the DAC outputs unmodified, including the extremes 0x00 and 0xFF.
- R8: The low-noise output-enable equals control bit 4.
- R9: The transmit/receive switch output is low while switch-control bit 2 (enable) is clear. When enabled, it is high in transmit if switch-control bit 0 is set. If that bit is clear, the output is high in receive or idle instead.
- R10: The polarization switch output equals switch-control bit 1 AND switch-control bit 3 (enable).
- R11: When a single write changes the transmit/receive state, the DAC codes and the switch output all change after the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| tr_pin | input | 1 | External transmit/receive pin, asynchronous |
| pa_code_o | output | 32 | Power-amplifier DAC codes, channel c in bits [8c+7:8c] |
| lna_code_o | output | 8 | Shared low-noise DAC code |
| lna_oe_o | output | 1 | Low-noise DAC output enable (low = high impedance) |
| tr_sw_o | output | 1 | External transmit/receive switch drive |
| pol_sw_o | output | 1 | Polarization switch drive |

## Verification
The hardest situation to bring about is the idle state with on and off codes that differ on every channel. Other cases can look right by chance: a code selection that swaps on and off for one side would still pass if the codes were equal. The idle state also only appears when both enables agree and the pin source is not selected. To reach it, random stimulus writes arbitrary codes and arbitrary control bytes, which lands in all three states and both sources. Directed cases also pin down idle explicitly, along with the pin synchronizer latency and the single-edge switchover.

// File: rtl/trx_bias_pkg.sv
// Package: shared types and register field positions for the
// transmit/receive bias and switch controller.
// Assumes register data is at least five bits wide.
package trx_bias_pkg;

    // Transmit/receive state seen by code selection and switch drivers.
    typedef enum logic [1:0] {
        TRS_IDLE = 2'd0,
        TRS_RX   = 2'd1,
        TRS_TX   = 2'd2
    } trs_e;

    // Control register bit positions.
    localparam int CTL_AUTO   = 0;
    localparam int CTL_PINSRC = 1;
    localparam int CTL_TXEN   = 2;
    localparam int CTL_RXEN   = 3;
    localparam int CTL_LNAOE  = 4;

    // Switch-control register bit positions.
    localparam int SWC_TRPOL  = 0;
    localparam int SWC_POLVAL = 1;
    localparam int SWC_TREN   = 2;
    localparam int SWC_POLEN  = 3;

    typedef struct packed {
        logic lna_oe;
        logic rx_en;
        logic tx_en;
        logic pin_src;
        logic auto_mode;
    } ctrl_t;

    typedef struct packed {
        logic pol_en;
        logic tr_en;
        logic pol_val;
        logic tr_pol;
    } swc_t;

endpackage

// File: rtl/trx_bias_regs.sv
// Module: register file holding on/off codes per channel plus the
// control and switch-control registers.
// Assumes ADDR_W >= CH_AW + 2 and CODE_W >= 5; unmapped addresses
// are ignored.
module trx_bias_regs
    import trx_bias_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 5,
    parameter int CH_AW  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CODE_W-1:0]             wr_data,
    output logic [NUM_CH-1:0][CODE_W-1:0] on_code_o,
    output logic [NUM_CH-1:0][CODE_W-1:0] off_code_o,
    output ctrl_t                         ctrl_o,
    output swc_t                          swc_o
);

    localparam int OFF_BASE  = 1 << CH_AW;
    localparam int CTRL_ADDR = 2 << CH_AW;
    localparam int SWC_ADDR  = CTRL_ADDR + 1;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Capture the on code of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                on_code_o[ch] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ch))
                on_code_o[ch] <= wr_data;
        end

        // Capture the off code of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                off_code_o[ch] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(OFF_BASE + ch))
                off_code_o[ch] <= wr_data;
        end
    end

    // Capture the control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            ctrl_o.auto_mode <= wr_data[CTL_AUTO];
            ctrl_o.pin_src   <= wr_data[CTL_PINSRC];
            ctrl_o.tx_en     <= wr_data[CTL_TXEN];
            ctrl_o.rx_en     <= wr_data[CTL_RXEN];
            ctrl_o.lna_oe    <= wr_data[CTL_LNAOE];
        end
    end

    // Capture the switch-control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swc_o <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(SWC_ADDR)) begin
            swc_o.tr_pol  <= wr_data[SWC_TRPOL];
            swc_o.pol_val <= wr_data[SWC_POLVAL];
            swc_o.tr_en   <= wr_data[SWC_TREN];
            swc_o.pol_en  <= wr_data[SWC_POLEN];
        end
    end

endmodule

// File: rtl/trx_tr_state.sv
// Module: synchronizes the TR pin and resolves the transmit/receive
// state from either the pin or the register enables.
// Assumes SYNC_STAGES >= 2; the pin is asynchronous to clk.
module trx_tr_state
    import trx_bias_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tr_pin,
    input  ctrl_t ctrl_i,
    output trs_e  state_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], tr_pin};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Resolve the state from the selected source.
    always_comb begin
        if (ctrl_i.pin_src)
            state_o = pin_s ? TRS_TX : TRS_RX;
        else if (ctrl_i.tx_en && !ctrl_i.rx_en)
            state_o = TRS_TX;
        else if (ctrl_i.rx_en && !ctrl_i.tx_en)
            state_o = TRS_RX;
        else
            state_o = TRS_IDLE;
    end

endmodule

// File: rtl/trx_bias_sel.sv
// Module: registered on/off code selection for one bias channel.
// IS_LNA picks the receive-active variant; otherwise the channel is
// active in transmit. Direct mode always passes the on code.
module trx_bias_sel
    import trx_bias_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter bit IS_LNA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] on_code_i,
    input  logic [CODE_W-1:0] off_code_i,
    input  logic              auto_mode_i,
    input  trs_e              state_i,
    output logic [CODE_W-1:0] code_o
);

    localparam trs_e ACTIVE_ST = IS_LNA ? TRS_RX : TRS_TX;

    logic              active;
    logic [CODE_W-1:0] code_d;

    // Decide whether the channel is biased on.
    always_comb begin
        active = !auto_mode_i || (state_i == ACTIVE_ST);
        code_d = active ? on_code_i : off_code_i;
    end

    // Register the selected code toward the DAC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_o <= '0;
        else
            code_o <= code_d;
    end

endmodule

// File: rtl/trx_sw_drv.sv
// Module: registered drivers for the transmit/receive switch, the
// polarization switch and the low-noise output enable.
// Assumes state_i comes from the same stage as the code selectors.
module trx_sw_drv
    import trx_bias_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  swc_t swc_i,
    input  logic lna_oe_i,
    input  trs_e state_i,
    output logic tr_sw_o,
    output logic pol_sw_o,
    output logic lna_oe_o
);

    logic is_tx;
    logic tr_d;

    // Apply polarity and enable to the transmit indication.
    always_comb begin
        is_tx = (state_i == TRS_TX);
        tr_d  = swc_i.tr_en && (swc_i.tr_pol ? is_tx : !is_tx);
    end

    // Register all switch-side outputs on a common edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_sw_o  <= 1'b0;
            pol_sw_o <= 1'b0;
            lna_oe_o <= 1'b0;
        end else begin
            tr_sw_o  <= tr_d;
            pol_sw_o <= swc_i.pol_en && swc_i.pol_val;
            lna_oe_o <= lna_oe_i;
        end
    end

endmodule

// File: rtl/trx_bias_ctrl.sv
// Module: top of the transmit/receive bias and switch controller.
// Channels 0..NUM_PA-1 are power-amplifier DACs; channel NUM_PA is
// the shared low-noise DAC. All outputs are registered.
module trx_bias_ctrl
    import trx_bias_pkg::*;
#(
    parameter int NUM_PA      = 4,
    parameter int CODE_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic                     tr_pin,
    output logic [NUM_PA*CODE_W-1:0] pa_code_o,
    output logic [CODE_W-1:0]        lna_code_o,
    output logic                     lna_oe_o,
    output logic                     tr_sw_o,
    output logic                     pol_sw_o
);

    localparam int NUM_CH = NUM_PA + 1;
    localparam int CH_AW  = $clog2(NUM_CH);

    logic [NUM_CH-1:0][CODE_W-1:0] on_code;
    logic [NUM_CH-1:0][CODE_W-1:0] off_code;
    logic [NUM_CH-1:0][CODE_W-1:0] dac_code;
    ctrl_t                         ctrl_q;
    swc_t                          swc_q;
    trs_e                          state;

    trx_bias_regs #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W),
        .CH_AW  (CH_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .on_code_o  (on_code),
        .off_code_o (off_code),
        .ctrl_o     (ctrl_q),
        .swc_o      (swc_q)
    );

    trx_tr_state #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .tr_pin  (tr_pin),
        .ctrl_i  (ctrl_q),
        .state_o (state)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
        trx_bias_sel #(
            .CODE_W (CODE_W),
            .IS_LNA (ch == NUM_PA)
        ) u_sel (
            .clk         (clk),
            .rst_n       (rst_n),
            .on_code_i   (on_code[ch]),
            .off_code_i  (off_code[ch]),
            .auto_mode_i (ctrl_q.auto_mode),
            .state_i     (state),
            .code_o      (dac_code[ch])
        );
    end

    for (genvar ch = 0; ch < NUM_PA; ch++) begin : g_pa_out
        assign pa_code_o[ch*CODE_W +: CODE_W] = dac_code[ch];
    end

    assign lna_code_o = dac_code[NUM_PA];

    trx_sw_drv u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .swc_i    (swc_q),
        .lna_oe_i (ctrl_q.lna_oe),
        .state_i  (state),
        .tr_sw_o  (tr_sw_o),
        .pol_sw_o (pol_sw_o),
        .lna_oe_o (lna_oe_o)
    );

endmodule

// File: rtl/trx_bias_chk.sv
// Module: assertion checker bound to trx_bias_ctrl. Observes ports
// and the registered mode bit; drives nothing back.
module trx_bias_chk
    import trx_bias_pkg::*;
#(
    parameter int NUM_PA = 4,
    parameter int CODE_W = 8,
    parameter int ADDR_W = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [CODE_W-1:0]        wr_data,
    input logic [NUM_PA*CODE_W-1:0] pa_code_o,
    input logic [CODE_W-1:0]        lna_code_o,
    input logic                     lna_oe_o,
    input logic                     tr_sw_o,
    input logic                     pol_sw_o,
    input logic                     auto_mode
);

    localparam int CH_AW     = $clog2(NUM_PA + 1);
    localparam int CTRL_ADDR = 2 << CH_AW;
    localparam int SWC_ADDR  = CTRL_ADDR + 1;

    logic wr_d1;
    logic auto_d1;

    // Delay the write strobe and mode bit by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_d1   <= 1'b0;
            auto_d1 <= 1'b0;
        end else begin
            wr_d1   <= wr_en;
            auto_d1 <= auto_mode;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pa_code_o == '0 && lna_code_o == '0 && !lna_oe_o && !tr_sw_o && !pol_sw_o)); // R1

    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_d1 && !auto_mode && !auto_d1) |=> ($stable(pa_code_o) && $stable(lna_code_o))); // R3

    AST_LNA_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> ##1 (lna_oe_o == $past(wr_data[CTL_LNAOE], 2))); // R8

    AST_TRSW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(SWC_ADDR) && !wr_data[SWC_TREN]) |=> ##1 !tr_sw_o); // R9

    AST_POLSW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(SWC_ADDR)) |=> ##1
            (pol_sw_o == ($past(wr_data[SWC_POLVAL], 2) && $past(wr_data[SWC_POLEN], 2)))); // R10

endmodule

bind trx_bias_ctrl trx_bias_chk #(
    .NUM_PA (NUM_PA),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pa_code_o  (pa_code_o),
    .lna_code_o (lna_code_o),
    .lna_oe_o   (lna_oe_o),
    .tr_sw_o    (tr_sw_o),
    .pol_sw_o   (pol_sw_o),
    .auto_mode  (ctrl_q.auto_mode)
);

// File: tb/sim_trx_bias_ctrl.sv
// Bench: directed corner cases plus seeded random register traffic,
// checked against a bench-side model of the requirements.
module sim_trx_bias_ctrl;

    localparam int NUM_PA = 4;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 5;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [CODE_W-1:0]        wr_data = '0;
    logic                     tr_pin = 1'b0;
    logic [NUM_PA*CODE_W-1:0] pa_code_o;
    logic [CODE_W-1:0]        lna_code_o;
    logic                     lna_oe_o;
    logic                     tr_sw_o;
    logic                     pol_sw_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of what has been written.
    logic [7:0] m_on [5];
    logic [7:0] m_off [5];
    logic [7:0] m_ctrl = '0;
    logic [7:0] m_swc = '0;
    logic       m_pin = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trx_bias_ctrl #(.NUM_PA(NUM_PA), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tr_pin(tr_pin), .pa_code_o(pa_code_o),
        .lna_code_o(lna_code_o), .lna_oe_o(lna_oe_o), .tr_sw_o(tr_sw_o),
        .pol_sw_o(pol_sw_o)
    );

    // State: 0 idle, 1 rx, 2 tx.
    function automatic int exp_state();
        if (m_ctrl[1]) return m_pin ? 2 : 1;
        if (m_ctrl[2] && !m_ctrl[3]) return 2;
        if (m_ctrl[3] && !m_ctrl[2]) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] exp_code(int ch);
        int st = exp_state();
        bit act;
        if (!m_ctrl[0]) return m_on[ch];
        act = (ch == 4) ? (st == 1) : (st == 2);
        return act ? m_on[ch] : m_off[ch];
    endfunction

    function automatic logic exp_trsw();
        bit tx = (exp_state() == 2);
        return m_swc[2] && (m_swc[0] ? tx : !tx);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < 4; c++)
            chk(req, $sformatf("pa_code[%0d]", c), int'(pa_code_o[c*8 +: 8]), int'(exp_code(c)));
        chk(req, "lna_code", int'(lna_code_o), int'(exp_code(4)));
        chk(req, "lna_oe", int'(lna_oe_o), int'(m_ctrl[4]));
        chk(req, "tr_sw", int'(tr_sw_o), int'(exp_trsw()));
        chk(req, "pol_sw", int'(pol_sw_o), int'(m_swc[1] && m_swc[3]));
    endtask

    // Write one register; returns at the negedge after the capture edge.
    task automatic wr(int addr, logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (addr < 5) m_on[addr] = data;
        else if (addr >= 8 && addr < 13) m_off[addr-8] = data;
        else if (addr == 16) m_ctrl = data & 8'h1F;
        else if (addr == 17) m_swc = data & 8'h0F;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        tr_pin = v; m_pin = v;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int a;
        logic [7:0] prev_pa0, prev_lna;
        logic prev_sw;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 5; c++) begin m_on[c] = '0; m_off[c] = '0; end
        tr_pin = 1'b1;              // pin high during reset must not leak
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tr_pin = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pa_code", int'(pa_code_o), 0);
        chk("R1", "lna_code", int'(lna_code_o), 0);
        chk("R1", "switches", int'({lna_oe_o, tr_sw_o, pol_sw_o}), 0);

        // R2: write latency, output changes after the next edge only
        wr(0, 8'h5A);
        chk("R2", "pa0 before update edge", int'(pa_code_o[7:0]), 0);
        @(negedge clk);
        chk("R2", "pa0 after update edge", int'(pa_code_o[7:0]), 8'h5A);

        // R7: extremes pass unmodified
        wr(1, 8'hFF); wr(2, 8'h00); wr(3, 8'h81); wr(4, 8'hFF);
        settle(); check_all("R7");

        // R3: direct mode ignores off codes, pin and enables
        for (int c = 0; c < 5; c++) wr(8 + c, 8'h30 + 8'(c));
        wr(16, 8'b0_0100);  // direct, tx_en set
        set_pin(1'b1);
        settle(); check_all("R3");
        wr(16, 8'b0_1010);  // direct, pin source, rx_en
        settle(); check_all("R3");
        set_pin(1'b0);

        // R4: automatic mode in transmit, receive, idle (both / neither)
        wr(16, 8'b0_0101); settle(); check_all("R4");
        chk("R4", "pa1 tx on", int'(pa_code_o[15:8]), 8'hFF);
        chk("R4", "lna tx off", int'(lna_code_o), 8'h34);
        wr(16, 8'b0_1001); settle(); check_all("R4");
        chk("R4", "pa0 rx off", int'(pa_code_o[7:0]), 8'h30);
        wr(16, 8'b0_1101); settle(); check_all("R4");
        chk("R4", "lna idle off", int'(lna_code_o), 8'h34);
        wr(16, 8'b0_0001); settle(); check_all("R4");

        // R5: pin source overrides enables
        wr(16, 8'b0_0111); settle(); check_all("R5");   // pin low -> rx
        chk("R5", "lna rx on via pin", int'(lna_code_o), 8'hFF);

        // R6: pin latency of three edges
        set_pin(1'b1);
        @(negedge clk); @(negedge clk);
        chk("R6", "pa1 after two edges", int'(pa_code_o[15:8]), 8'h31);
        @(negedge clk);
        chk("R6", "pa1 after three edges", int'(pa_code_o[15:8]), 8'hFF);
        settle(); check_all("R6");

        // R8: low-noise output enable
        wr(16, 8'b1_0111); settle(); check_all("R8");
        wr(16, 8'b0_0111); settle(); check_all("R8");

        // R9: switch polarity and enable
        wr(17, 8'b0101); settle(); check_all("R9");     // en, pol=1, tx
        chk("R9", "tr_sw high in tx", int'(tr_sw_o), 1);
        wr(17, 8'b0100); settle(); check_all("R9");     // pol=0, tx -> low
        set_pin(1'b0); settle(); check_all("R9");       // pol=0, rx -> high
        chk("R9", "tr_sw high in rx pol0", int'(tr_sw_o), 1);
        wr(17, 8'b0001); settle(); check_all("R9");     // disabled

        // R10: polarization switch
        wr(17, 8'b1010); settle(); check_all("R10");
        chk("R10", "pol_sw on", int'(pol_sw_o), 1);
        wr(17, 8'b0010); settle(); check_all("R10");

        // R11: one write switches tx->rx; all outputs move on one edge
        wr(17, 8'b0101);
        wr(16, 8'b0_0101); settle();
        prev_pa0 = pa_code_o[7:0]; prev_lna = lna_code_o; prev_sw = tr_sw_o;
        wr(16, 8'b0_1001);
        chk("R11", "pa0 held", int'(pa_code_o[7:0]), int'(prev_pa0));
        chk("R11", "lna held", int'(lna_code_o), int'(prev_lna));
        chk("R11", "tr_sw held", int'(tr_sw_o), int'(prev_sw));
        @(negedge clk);
        check_all("R11");

        // Random traffic over all registers and the pin.
        for (int i = 0; i < 600; i++) begin
            a = int'($urandom_range(0, 12));
            if (a < 5) wr(a, 8'($urandom));
            else if (a < 10) wr(a + 3, 8'($urandom));
            else if (a == 10) wr(16, 8'($urandom));
            else if (a == 11) wr(17, 8'($urandom));
            else set_pin(~m_pin);
            settle();
            check_all(m_ctrl[0] ? (m_ctrl[1] ? "R5" : "R4") : "R3");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule